// File: doc/BRIEF.md
# Latency-Insensitive Two-Output Dataflow Node

This block turns a combinational function into a node of a dataflow network whose edges are bounded FIFOs kept outside the block. It reads two input queues, `a` and `b`, through their valid flag, head value and dequeue strobe. It writes two output queues through their room flag and enqueue strobe. Output `c` carries `f(a, b)`. Output `d` carries the head of `b` unchanged.

Each output fires on its own. It fires once the inputs it really depends on are present and its own queue has room. A per-output done flag stops it from producing the same token twice. The inputs are consumed only after both outputs of the current token are done. Output `d` never waits for `a`, so a network can feed `d` back into `a` without deadlock. A version that made every output wait on every input and on every output queue would lock up in that loop.

The function is chosen by a parameter: `OP` = 0 is a sum, 1 is XOR, 2 is AND and 3 is the difference `a - b`. Every result is taken modulo 2^W. A token takes at least two cycles: one to produce the outputs and one to consume the inputs.

Top module: `li_pair_node`

## Requirements
- R1: While `rst_n` is low, `c_push`, `d_push`, `a_pop` and `b_pop` are all 0. Both done flags come out of reset clear, so a token that is present when reset is released fires its outputs in that same cycle.
- R2: `c_push` is asserted combinationally when all four of these hold: c's done flag is clear, `a_valid` is 1, `b_valid` is 1 and `c_room` is 1. In that cycle `c_data` equals f(`a_head`, `b_head`), where f with the default `OP`=0 is (`a_head` + `b_head`) mod 2^W.
- R3: `d_push` is asserted when d's done flag is clear, `b_valid` is 1 and `d_room` is 1, whatever the value of `a_valid`. In that cycle `d_data` equals `b_head`.
- R4: Each output is enqueued exactly once per input token, however long the other output or the inputs stall.
- R5: `a_pop` and `b_pop` are asserted together for exactly one cycle. That cycle comes after the cycles in which both outputs of the token have fired, and the pop is never issued to an empty input. Popping clears both done flags.
- R6: The nth value enqueued on `c` is f of the nth values of `a` and `b`. The nth value enqueued on `d` is the nth value of `b`. This holds under any pattern of input arrival gaps and output room stalls.
- R7: The sum wraps modulo 2^W. With W=8, 200 + 100 gives 44.
- R8: When `d` feeds `a` through a one-entry queue that starts empty, every token of `b` is processed. Token n then yields `c` = 2·b(n) mod 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Queue a holds a value |
| a_head | input | W | Head value of queue a |
| a_pop | output | 1 | Dequeue strobe for queue a |
| b_valid | input | 1 | Queue b holds a value |
| b_head | input | W | Head value of queue b |
| b_pop | output | 1 | Dequeue strobe for queue b |
| c_room | input | 1 | Queue c can accept a value |
| c_push | output | 1 | Enqueue strobe for queue c |
| c_data | output | W | Value written to queue c |
| d_room | input | 1 | Queue d can accept a value |
| d_push | output | 1 | Enqueue strobe for queue d |
| d_data | output | W | Value written to queue d |

## Verification
The hardest state to reach is a token whose outputs have fired only partly. In that state one done flag has been set, and it must hold for several cycles while the other output or input is still missing, without a repeated enqueue or an early dequeue. The bench forces this by holding one room flag low, or by enqueuing `b` well before `a`. It then watches the strobes cycle by cycle. It also closes a one-entry loop from `d` back to `a`, where forward progress depends on `d` firing before `a` exists. It also runs a long stream with random room stalls and staggered input arrivals.

// File: rtl/li_pair_node.sv
module li_pair_node #(
  parameter int W  = 8,
  parameter int OP = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_valid,
  input  logic [W-1:0] a_head,
  output logic         a_pop,
  input  logic         b_valid,
  input  logic [W-1:0] b_head,
  output logic         b_pop,
  input  logic         c_room,
  output logic         c_push,
  output logic [W-1:0] c_data,
  input  logic         d_room,
  output logic         d_push,
  output logic [W-1:0] d_data
);

  function automatic logic [W-1:0] f_op(input logic [W-1:0] x, input logic [W-1:0] y);
    case (OP)
      1:       f_op = x ^ y;
      2:       f_op = x & y;
      3:       f_op = x - y;
      default: f_op = x + y;
    endcase
  endfunction

  logic c_done, d_done;
  logic finish;

  assign c_push = rst_n && !c_done && a_valid && b_valid && c_room;
  assign d_push = rst_n && !d_done && b_valid && d_room;
  assign finish = rst_n && c_done && d_done;
  assign a_pop  = finish;
  assign b_pop  = finish;
  assign c_data = f_op(a_head, b_head);
  assign d_data = b_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_done <= 1'b0;
      d_done <= 1'b0;
    end else if (finish) begin
      c_done <= 1'b0;
      d_done <= 1'b0;
    end else begin
      if (c_push) c_done <= 1'b1;
      if (d_push) d_done <= 1'b1;
    end
  end

  // R1
  always_comb begin
    if (!rst_n) quiet_in_reset_chk: assert (!c_push && !d_push && !a_pop && !b_pop);
  end

  // R2
  c_push_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_push |-> (a_valid && b_valid && c_room));

  // R3
  d_push_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_push |-> (b_valid && d_room));

  // R4
  c_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_push |=> !c_push);

  // R4
  d_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_push |=> !d_push);

  // R5
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_pop |-> (a_valid && b_valid));

  // R5
  pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_pop |=> !a_pop);

  // R5
  pop_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_pop |-> (!c_push && !d_push));

endmodule

// File: tb/tb_li_pair_node.sv
`timescale 1ns/1ps
module tb_li_pair_node;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic a_valid, b_valid, c_room, d_room;
  logic [W-1:0] a_head, b_head, c_data, d_data;
  logic a_pop, b_pop, c_push, d_push;

  li_pair_node #(.W(W), .OP(0)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_head(a_head), .a_pop(a_pop),
    .b_valid(b_valid), .b_head(b_head), .b_pop(b_pop),
    .c_room(c_room), .c_push(c_push), .c_data(c_data),
    .d_room(d_room), .d_push(d_push), .d_data(d_data)
  );

  logic [W-1:0] aq [0:511];
  logic [W-1:0] bq [0:511];
  logic [W-1:0] c_log [0:511];
  logic [W-1:0] d_log [0:511];
  int a_len = 0, b_len = 0, a_ix = 0, b_ix = 0, c_n = 0, d_n = 0;
  logic loop_mode = 1'b0, stall_en = 1'b0, c_sel = 1'b1, d_sel = 1'b1;
  logic fb_full = 1'b0;
  logic [W-1:0] fb_val = '0;
  logic [15:0] lfsr = 16'hACE1;
  int errors = 0, checks = 0;

  assign a_valid = loop_mode ? fb_full : (a_ix < a_len);
  assign a_head  = loop_mode ? fb_val : aq[a_ix];
  assign b_valid = (b_ix < b_len);
  assign b_head  = bq[b_ix];
  assign c_room  = c_sel && (!stall_en || lfsr[1]);
  assign d_room  = loop_mode ? !fb_full : (d_sel && (!stall_en || lfsr[6]));

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n) begin
      if (c_push) begin c_log[c_n] <= c_data; c_n <= c_n + 1; end
      if (d_push) begin d_log[d_n] <= d_data; d_n <= d_n + 1; end
      if (a_pop && !loop_mode) a_ix <= a_ix + 1;
      if (b_pop) b_ix <= b_ix + 1;
      if (loop_mode) begin
        if (d_push) begin fb_full <= 1'b1; fb_val <= d_data; end
        else if (a_pop) fb_full <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); #1; endtask
  task automatic push_a(input int v); aq[a_len] = v[W-1:0]; a_len++; endtask
  task automatic push_b(input int v); bq[b_len] = v[W-1:0]; b_len++; endtask
  task automatic push_tok(input int x, input int y); push_a(x); push_b(y); endtask

  task automatic strobes(input string rq, input bit ec, input bit ed, input bit ep);
    chk(c_push == ec, {rq, " c_push"}, int'(c_push), int'(ec));
    chk(d_push == ed, {rq, " d_push"}, int'(d_push), int'(ed));
    chk(a_pop == ep && b_pop == ep, {rq, " pop"}, int'(a_pop), int'(ep));
  endtask

  task automatic t_reset;
    @(negedge clk);
    push_tok(1, 2);
    for (int k = 0; k < 3; k++) begin tick; strobes("R1 in reset", 0, 0, 0); end
    @(negedge clk); rst_n = 1'b1; #1;
    strobes("R1 first token", 1, 1, 0);
    chk(c_data == 8'd3, "R1 c_data", c_data, 3);
    tick; strobes("R5 finish", 0, 0, 1);
    tick; strobes("R5 idle", 0, 0, 0);
  endtask

  task automatic t_single(input int x, input int y, input string rq);
    push_tok(x, y); #1;
    strobes({rq, " fire"}, 1, 1, 0);
    chk(c_data == W'(x + y), {rq, " c_data"}, c_data, (x + y) & 255);
    chk(d_data == W'(y), "R3 d_data", d_data, y);
    tick; strobes("R5 pop cycle", 0, 0, 1);
    tick; strobes("R4 idle after", 0, 0, 0);
  endtask

  task automatic t_d_only;
    push_b(9); #1;
    strobes("R3 d without a", 0, 1, 0);
    chk(d_data == 8'd9, "R3 d_data", d_data, 9);
    for (int k = 0; k < 3; k++) begin tick; strobes("R4 wait for a", 0, 0, 0); end
    push_a(4); #1;
    strobes("R2 late a", 1, 0, 0);
    chk(c_data == 8'd13, "R2 c_data", c_data, 13);
    tick; strobes("R5 pop", 0, 0, 1);
    tick; strobes("R5 idle", 0, 0, 0);
  endtask

  task automatic t_stalls;
    c_sel = 1'b0; push_tok(3, 4); #1;
    strobes("R3 c stalled", 0, 1, 0);
    for (int k = 0; k < 2; k++) begin tick; strobes("R4 c stalled hold", 0, 0, 0); end
    c_sel = 1'b1; #1;
    strobes("R2 c released", 1, 0, 0);
    chk(c_data == 8'd7, "R2 c_data", c_data, 7);
    tick; strobes("R5 pop", 0, 0, 1);
    tick; d_sel = 1'b0; push_tok(10, 20); #1;
    strobes("R2 d stalled", 1, 0, 0);
    for (int k = 0; k < 2; k++) begin tick; strobes("R4 d stalled hold", 0, 0, 0); end
    d_sel = 1'b1; #1;
    strobes("R3 d released", 0, 1, 0);
    chk(d_data == 8'd20, "R3 d_data", d_data, 20);
    tick; strobes("R5 pop", 0, 0, 1);
    tick;
  endtask

  task automatic t_stream;
    int cs, ds, na, nb;
    cs = c_n; ds = d_n; na = 0; nb = 0;
    stall_en = 1'b1;
    for (int k = 0; k < 3000 && !(na == 40 && nb == 40 && c_n - cs == 40 && d_n - ds == 40 && b_ix == b_len); k++) begin
      if (na < 40 && ($urandom % 2) == 1) begin push_a((na * 37 + 11) & 255); na++; end
      if (nb < 40 && ($urandom % 3) != 0) begin push_b((nb * 53 + 200) & 255); nb++; end
      tick;
    end
    stall_en = 1'b0;
    tick; tick;
    chk(c_n - cs == 40, "R4 stream c count", c_n - cs, 40);
    chk(d_n - ds == 40, "R4 stream d count", d_n - ds, 40);
    for (int i = 0; i < 40; i++) begin
      int ea, eb;
      ea = (i * 37 + 11) & 255; eb = (i * 53 + 200) & 255;
      chk(c_log[cs + i] == W'(ea + eb), "R6 stream c", c_log[cs + i], (ea + eb) & 255);
      chk(d_log[ds + i] == W'(eb), "R6 stream d", d_log[ds + i], eb);
    end
  endtask

  task automatic t_loop;
    int cs, ds, bs;
    cs = c_n; ds = d_n; bs = b_len;
    loop_mode = 1'b1; stall_en = 1'b1;
    for (int i = 0; i < 20; i++) push_b((i * 29 + 5) & 255);
    for (int k = 0; k < 2000 && (c_n - cs < 20 || b_ix < b_len); k++) tick;
    stall_en = 1'b0;
    chk(c_n - cs == 20, "R8 loop progress", c_n - cs, 20);
    chk(b_ix == b_len, "R8 loop b drained", b_ix - bs, 20);
    for (int i = 0; i < 20; i++) begin
      int eb;
      eb = (i * 29 + 5) & 255;
      chk(c_log[cs + i] == W'(eb + eb), "R8 loop c", c_log[cs + i], (eb + eb) & 255);
      chk(d_log[ds + i] == W'(eb), "R8 loop d", d_log[ds + i], eb);
    end
    tick; loop_mode = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset;
    t_single(5, 7, "R2");
    t_single(200, 100, "R7");
    t_d_only;
    t_stalls;
    t_stream;
    t_loop;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule